// File: doc/BRIEF.md
# E1 Sa6 Pattern Error Counter with Host Snapshot

This block is a performance-monitoring counter for an E1 receive path. In its normal mode it watches the Sa6 spare bit. Each CRC submultiframe carries four Sa6 bits. The block gathers them in arrival order and counts every submultiframe whose group reads `0010` or `0011`. The first bit of a group is the one carried in frame 1 or frame 9 of the multiframe. Counting needs CRC multiframe operation and held multiframe alignment. The live counter saturates and never wraps.

In the alternate mode the low byte is split into two fields. Bits 7:2 form a six-bit counter of multiframe periods spent without frame or multiframe alignment. Bits 1:0 form a two-bit counter of alignment changes. The high byte reads zero. An alarm-simulation input forces one count per submultiframe in normal mode, or one count per multiframe in both alternate fields.

The host reads a buffered copy of the counter through a small byte-wide register port. The buffer has two update modes:
- **Manual mode:** the buffer follows the live counter until the host sets a freeze bit. The rising edge of that bit captures the buffer and clears the live counter. Reading the high byte drops the freeze bit again.
- **Automatic mode:** a one-second tick copies the counter into the buffer, clears the counter and pulses an interrupt output.

Frame alignment search and CRC checking are outside this block.

Top module: `e1_sa6_monitor`

## Requirements
- R1: With `crc_mode`=1, `alt_mode`=0 and `lmfa`=0, the live counter increments by one on each `smf_stb` that follows exactly four `sa6_vld` bits whose values, first-received bit as MSB, equal 4'b0010 or 4'b0011; any other group leaves it unchanged.
- R2: While `lmfa`=1, no group is counted in normal mode. A pulse of `lmfa` inside a submultiframe discards the bits gathered so far, so a group with fewer than four bits after the pulse is not counted.
- R3: With `crc_mode`=0 and `alt_mode`=0 the live counter never increases, even with `alarm_sim`=1.
- R4: Every counter saturates at its all-ones value and never wraps to zero: the normal counter at 2^CNT_W-1, the alternate fields at 63 and 3.
- R5: With `alarm_sim`=1 the normal counter increments once per `smf_stb`, and in alternate mode both fields increment once per `mf_stb`, each up to saturation.
- R6: With `alt_mode`=1, bits 7:2 of the low byte increment on each `mf_stb` while `lfa` or `lmfa` is 1, bits 1:0 increment on each `align_chg` pulse, and the high byte reads zero.
- R7: With `auto_latch`=0 and the freeze bit clear, the buffer follows the live counter one clock later. Writing 1 to bit 0 of address 2 while it is 0 freezes the buffer at the current count and clears the live counter. A read of address 1 clears the freeze bit.
- R8: With `auto_latch`=1, each `sec_tick` copies the live counter into the buffer and clears the counter, and `sec_irq` is high for exactly the following clock. With `auto_latch`=0, `sec_tick` neither clears the counter nor raises `sec_irq`.
- R9: When a counting event and a clear (freeze edge or one-second latch) fall in the same clock, the buffer receives the old count and the live counter restarts at 1.
- R10: Register map: address 0 = buffer bits 7:0, address 1 = buffer bits CNT_W-1:8 zero-extended, address 2 = freeze bit in bit 0. Writes to addresses 0 and 1 have no effect, and all counters, the buffer and the freeze bit reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa6_vld | input | 1 | One-clock strobe: `sa6_bit` carries a received Sa6 bit |
| sa6_bit | input | 1 | Received Sa6 bit value |
| smf_stb | input | 1 | One-clock pulse at the end of each CRC submultiframe |
| mf_stb | input | 1 | One-clock pulse once per multiframe period |
| lfa | input | 1 | Frame alignment lost |
| lmfa | input | 1 | Multiframe alignment lost |
| align_chg | input | 1 | One-clock pulse on a detected change of frame/multiframe alignment |
| crc_mode | input | 1 | 1 = CRC multiframe format, 0 = doubleframe format |
| alt_mode | input | 1 | 1 = split alignment counters, 0 = Sa6 pattern counter |
| auto_latch | input | 1 | 1 = one-second latch-and-clear, 0 = host freeze |
| alarm_sim | input | 1 | Alarm simulation: forced counting |
| sec_tick | input | 1 | One-clock one-second tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| sec_irq | output | 1 | One-clock pulse after each latching tick |

## Verification
The bench builds the block with CNT_W=10, so the normal counter saturates at 1023. That value is reachable within a few thousand cycles of forced counting. It also leaves two live bits in the high byte, which tests the byte split and the zero-extension. The alternate-mode fields keep their fixed six and two bits. Their saturation is reached with about seventy multiframe pulses, and the pulses that follow show that the count holds at the ceiling.

// File: rtl/e1s6_pkg.sv
package e1s6_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned RD_W   = 16;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/e1s6_grp.sv
// Gathers Sa6 bits of one submultiframe and flags a matching, complete group.
module e1s6_grp #(
    parameter int unsigned         GRP_LEN = 4,
    parameter logic [GRP_LEN-1:0]  PAT_A   = GRP_LEN'(2),
    parameter logic [GRP_LEN-1:0]  PAT_B   = GRP_LEN'(3)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic smf_stb,
    input  logic lmfa,
    output logic grp_hit
);
    localparam int unsigned NW = $clog2(GRP_LEN + 2);

    typedef struct packed {
        logic [GRP_LEN-1:0] sh;
        logic [NW-1:0]      n;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lmfa || smf_stb) begin
            // loss of alignment or group boundary: restart gathering
            st_d.n = '0;
        end else if (bit_vld) begin
            st_d.sh = {st_q.sh[GRP_LEN-2:0], bit_in};
            if (st_q.n != NW'(GRP_LEN + 1)) begin
                st_d.n = st_q.n + 1'b1;
            end
        end
    end

    assign grp_hit = smf_stb && !lmfa && (st_q.n == NW'(GRP_LEN))
                     && ((st_q.sh == PAT_A) || (st_q.sh == PAT_B));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/e1s6_cnt.sv
// Live counter: saturating Sa6 pattern counter, or split alignment counters.
module e1s6_cnt #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned MF_W  = 6,
    parameter int unsigned CHG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             crc_mode,
    input  logic             alt_mode,
    input  logic             alarm_sim,
    input  logic             grp_hit,
    input  logic             smf_stb,
    input  logic             mf_stb,
    input  logic             lfa,
    input  logic             lmfa,
    input  logic             align_chg,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int unsigned LOW_W = MF_W + CHG_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [MF_W-1:0]  mf_f;
    logic [CHG_W-1:0] chg_f;
    logic             norm_inc, mf_inc, chg_inc;

    always_comb begin
        st_d     = st_q;
        base     = clr ? '0 : st_q.cnt;
        norm_inc = crc_mode && smf_stb && (alarm_sim || grp_hit);
        mf_inc   = mf_stb && (alarm_sim || lfa || lmfa);
        chg_inc  = alarm_sim ? mf_stb : align_chg;
        mf_f     = base[LOW_W-1:CHG_W];
        chg_f    = base[CHG_W-1:0];
        if (!alt_mode) begin
            st_d.cnt = base;
            if (norm_inc && (base != '1)) begin
                st_d.cnt = base + 1'b1;
            end
        end else begin
            if (mf_inc && (mf_f != '1)) begin
                mf_f = mf_f + 1'b1;
            end
            if (chg_inc && (chg_f != '1)) begin
                chg_f = chg_f + 1'b1;
            end
            st_d.cnt = '0;
            st_d.cnt[LOW_W-1:0] = {mf_f, chg_f};
        end
    end

    assign cnt_q = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/e1s6_host.sv
// Read buffer, freeze control and one-second latch.
module e1s6_host
    import e1s6_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic              wbit,
    input  logic              auto_latch,
    input  logic              sec_tick,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic              clr,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  buf_q,
    output logic              freeze_q,
    output logic              irq_q
);
    typedef struct packed {
        logic             freeze;
        logic [CNT_W-1:0] bufv;
        logic             irq;
    } host_st_t;

    host_st_t        st_d, st_q;
    logic [RD_W-1:0] ext;
    reg_addr_e       a;

    assign a = reg_addr_e'(reg_addr);

    always_comb begin
        st_d = st_q;
        if (reg_wr && (a == REG_CTL)) begin
            st_d.freeze = wbit;
        end else if (reg_rd && (a == REG_HI)) begin
            st_d.freeze = 1'b0;
        end
        if (auto_latch) begin
            clr = sec_tick;
            if (sec_tick) st_d.bufv = live_cnt;
        end else begin
            clr = st_d.freeze && !st_q.freeze;
            if (!st_q.freeze) st_d.bufv = live_cnt;
        end
        st_d.irq = auto_latch && sec_tick;
    end

    always_comb begin
        ext = '0;
        ext[CNT_W-1:0] = st_q.bufv;
        case (a)
            REG_LO:  rdata = ext[BYTE_W-1:0];
            REG_HI:  rdata = ext[RD_W-1:BYTE_W];
            REG_CTL: rdata = {{(BYTE_W-1){1'b0}}, st_q.freeze};
            default: rdata = '0;
        endcase
    end

    assign buf_q    = st_q.bufv;
    assign freeze_q = st_q.freeze;
    assign irq_q    = st_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/e1_sa6_monitor.sv
module e1_sa6_monitor #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned GRP_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sa6_vld,
    input  logic       sa6_bit,
    input  logic       smf_stb,
    input  logic       mf_stb,
    input  logic       lfa,
    input  logic       lmfa,
    input  logic       align_chg,
    input  logic       crc_mode,
    input  logic       alt_mode,
    input  logic       auto_latch,
    input  logic       alarm_sim,
    input  logic       sec_tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sec_irq
);
    logic             grp_hit;
    logic             clr;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] buf_val;
    logic             freeze;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[7:1];

    e1s6_grp #(.GRP_LEN(GRP_LEN)) u_grp (
        .clk(clk), .rst_n(rst_n), .bit_vld(sa6_vld), .bit_in(sa6_bit),
        .smf_stb(smf_stb), .lmfa(lmfa), .grp_hit(grp_hit)
    );

    e1s6_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .crc_mode(crc_mode),
        .alt_mode(alt_mode), .alarm_sim(alarm_sim), .grp_hit(grp_hit),
        .smf_stb(smf_stb), .mf_stb(mf_stb), .lfa(lfa), .lmfa(lmfa),
        .align_chg(align_chg), .cnt_q(live_cnt)
    );

    e1s6_host #(.CNT_W(CNT_W)) u_host (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .wbit(reg_wdata[0]), .auto_latch(auto_latch),
        .sec_tick(sec_tick), .live_cnt(live_cnt), .clr(clr),
        .rdata(reg_rdata), .buf_q(buf_val), .freeze_q(freeze), .irq_q(sec_irq)
    );
endmodule

// File: rtl/e1s6_chk.sv
module e1s6_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crc_mode,
    input logic             alt_mode,
    input logic             auto_latch,
    input logic             alarm_sim,
    input logic             lmfa,
    input logic             sec_tick,
    input logic             sec_irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] buf_q,
    input logic             freeze_q
);
    assert_no_count_unaligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode && lmfa && !alarm_sim) |=> (cnt_q <= $past(cnt_q)));

    assert_doubleframe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_mode && !alt_mode) |=> (cnt_q <= $past(cnt_q)));

    // a drop is only ever a clear, after which at most one event is counted
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode) |=> ((cnt_q >= $past(cnt_q)) || (cnt_q <= CNT_W'(1))));

    assert_alt_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alt_mode |=> (cnt_q[CNT_W-1:8] == '0));

    assert_frozen_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_latch && freeze_q) |=> $stable(buf_q));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> $past(sec_tick && auto_latch));

    assert_irq_follows_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && auto_latch) |=> sec_irq);
endmodule

bind e1_sa6_monitor e1s6_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .crc_mode(crc_mode), .alt_mode(alt_mode),
    .auto_latch(auto_latch), .alarm_sim(alarm_sim), .lmfa(lmfa),
    .sec_tick(sec_tick), .sec_irq(sec_irq), .cnt_q(live_cnt),
    .buf_q(buf_val), .freeze_q(freeze)
);

// File: tb/e1_sa6_monitor_tb.sv
module e1_sa6_monitor_tb;
    localparam int unsigned CW  = 10;
    localparam int          MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sa6_vld = 0, sa6_bit = 0, smf_stb = 0, mf_stb = 0;
    logic lfa = 0, lmfa = 0, align_chg = 0;
    logic crc_mode = 1, alt_mode = 0, auto_latch = 0, alarm_sim = 0, sec_tick = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic sec_irq;

    int n_run = 0, n_fail = 0;
    int expc = 0;
    int v;

    always #10 clk = ~clk;

    e1_sa6_monitor #(.CNT_W(CW)) u_dut (.*);

    function automatic int sat_inc(int x, int mx);
        return (x >= mx) ? mx : x + 1;
    endfunction

    function automatic bit is_hit(logic [3:0] b);
        return (b == 4'b0010) || (b == 4'b0011);
    endfunction

    task automatic check(string req, int act, int exp_v);
        n_run++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic reg_read(logic [1:0] a, output int d);
        reg_rd = 1; reg_addr = a;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic snap(output int val);
        int lo, hi;
        reg_write(2'd2, 8'h01);
        idle(1);
        reg_read(2'd0, lo);
        reg_read(2'd1, hi);
        val = (hi << 8) | lo;
    endtask

    task automatic track(output int val);
        int lo, hi;
        idle(2);
        reg_read(2'd0, lo);
        reg_read(2'd1, hi);
        val = (hi << 8) | lo;
    endtask

    task automatic send_bits(logic [3:0] b, logic lm);
        for (int i = 3; i >= 0; i--) begin
            sa6_vld = 1; sa6_bit = b[i]; lmfa = lm;
            @(negedge clk);
            sa6_vld = 0;
            @(negedge clk);
        end
    endtask

    task automatic send_group(logic [3:0] b, logic lm);
        send_bits(b, lm);
        smf_stb = 1;
        @(negedge clk);
        smf_stb = 0;
        if (crc_mode && !alt_mode && (alarm_sim || (!lm && is_hit(b))))
            expc = sat_inc(expc, MAXC);
    endtask

    task automatic pulse_mf();
        mf_stb = 1; @(negedge clk); mf_stb = 0; @(negedge clk);
    endtask

    task automatic pulse_chg();
        align_chg = 1; @(negedge clk); align_chg = 0; @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1357));
        idle(3);
        rst_n = 1;
        idle(2);

        // R10 reset values and register map
        reg_read(2'd0, v); check("R10 reset low byte", v, 0);
        reg_read(2'd1, v); check("R10 reset high byte", v, 0);
        reg_read(2'd2, v); check("R10 reset freeze bit", v, 0);
        check("R10 reset irq", int'(sec_irq), 0);
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'hFF);
        track(v); check("R10 writes to count bytes ignored", v, 0);

        // R1 directed patterns, tracked buffer (R7)
        send_group(4'b0010, 0);
        send_group(4'b0011, 0);
        send_group(4'b0110, 0);
        send_group(4'b1010, 0);
        send_group(4'b0001, 0);
        track(v); check("R1 two matching groups of five", v, 2);
        check("R1 model agrees", expc, 2);

        // R2 held loss of alignment and partial group
        send_group(4'b0010, 1);
        send_group(4'b0011, 1);
        track(v); check("R2 no count while lmfa", v, expc);
        send_bits(4'b0000, 0);          // gather some bits first
        sa6_vld = 1; sa6_bit = 0; @(negedge clk); sa6_vld = 0;
        sa6_vld = 1; sa6_bit = 0; @(negedge clk); sa6_vld = 0;
        lmfa = 1; @(negedge clk); lmfa = 0;
        sa6_vld = 1; sa6_bit = 1; @(negedge clk); sa6_vld = 0;
        sa6_vld = 1; sa6_bit = 0; @(negedge clk); sa6_vld = 0;
        smf_stb = 1; @(negedge clk); smf_stb = 0;
        track(v); check("R2 partial group after lmfa discarded", v, expc);

        // R7 snapshot clears live counter and freeze clears on high read
        snap(v); check("R7 snapshot value", v, expc);
        expc = 0;
        reg_read(2'd2, v); check("R7 freeze bit cleared by high read", v, 0);
        track(v); check("R7 live counter cleared by snapshot", v, 0);

        // R1/R2/R5 random traffic
        for (int k = 0; k < 300; k++) begin
            logic [3:0] b;
            logic lm;
            b  = 4'($urandom_range(0, 15));
            if (($urandom % 3) == 0) b = 4'b0010 | 4'($urandom % 2);
            lm = (($urandom % 4) == 0);
            alarm_sim = (($urandom % 8) == 0);
            send_group(b, lm);
        end
        alarm_sim = 0; lmfa = 0;
        snap(v); check("R1 random traffic snapshot", v, expc);
        expc = 0;

        // R3 doubleframe
        crc_mode = 0;
        send_group(4'b0010, 0);
        alarm_sim = 1;
        send_group(4'b0011, 0);
        alarm_sim = 0;
        track(v); check("R3 doubleframe never counts", v, 0);
        crc_mode = 1;

        // R4/R5 saturation with alarm simulation
        alarm_sim = 1;
        for (int k = 0; k < MAXC + 40; k++) begin
            smf_stb = 1; @(negedge clk); smf_stb = 0; @(negedge clk);
            expc = sat_inc(expc, MAXC);
        end
        alarm_sim = 0;
        track(v); check("R5 alarm sim counts each submultiframe", v, expc);
        check("R4 saturates at max", v, MAXC);
        send_group(4'b0010, 0);
        track(v); check("R4 no wrap after extra event", v, MAXC);
        snap(v); check("R4 snapshot at max", v, MAXC);
        expc = 0;

        // R9 event and freeze edge in the same clock
        send_group(4'b0011, 0);
        send_group(4'b0010, 0);
        send_bits(4'b0010, 0);
        smf_stb = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h01;
        @(negedge clk);
        smf_stb = 0; reg_wr = 0; reg_wdata = 0;
        idle(1);
        reg_read(2'd0, v); check("R9 frozen buffer holds old count", v, 2);
        reg_read(2'd1, v);
        snap(v); check("R9 coincident event counted in new interval", v, 1);
        expc = 0;

        // R8 manual mode ignores tick
        send_group(4'b0010, 0);
        sec_tick = 1; @(negedge clk); sec_tick = 0;
        #1 check("R8 no irq in manual mode", int'(sec_irq), 0);
        track(v); check("R8 tick does not clear in manual mode", v, 1);
        expc = 1;

        // R8 automatic latch
        auto_latch = 1;
        sec_tick = 1; @(negedge clk); sec_tick = 0;
        expc = 0;
        send_group(4'b0010, 0);
        send_group(4'b0011, 0);
        send_group(4'b0011, 0);
        sec_tick = 1; @(negedge clk); sec_tick = 0;
        #1 check("R8 irq after tick", int'(sec_irq), 1);
        @(negedge clk);
        #1 check("R8 irq lasts one clock", int'(sec_irq), 0);
        reg_read(2'd0, v); check("R8 latched count", v, 3);
        send_group(4'b0010, 0);
        reg_read(2'd0, v); check("R8 buffer steady between ticks", v, 3);
        // R9 with one-second latch: event in tick clock
        send_bits(4'b0011, 0);
        smf_stb = 1; sec_tick = 1; @(negedge clk); smf_stb = 0; sec_tick = 0;
        reg_read(2'd0, v); check("R9 tick latch gets old count", v, 1);
        sec_tick = 1; @(negedge clk); sec_tick = 0;
        reg_read(2'd0, v); check("R9 coincident event in next second", v, 1);
        auto_latch = 0;
        idle(1);

        // R6 alternate mode
        alt_mode = 1;
        snap(v);
        lfa = 1;
        repeat (5) pulse_mf();
        lfa = 0;
        repeat (2) pulse_chg();
        repeat (3) pulse_mf();
        track(v); check("R6 split fields mf=5 chg=2", v, (5 << 2) | 2);
        lmfa = 1; pulse_mf(); lmfa = 0;
        track(v); check("R6 lmfa also counts periods", v, (6 << 2) | 2);
        alarm_sim = 1;
        repeat (70) pulse_mf();
        alarm_sim = 0;
        repeat (3) pulse_chg();
        lfa = 1; repeat (2) pulse_mf(); lfa = 0;
        track(v); check("R5 alt alarm sim saturates both fields", v, 255);
        reg_read(2'd1, v); check("R6 high byte zero in alt mode", v, 0);
        snap(v); check("R4 alt snapshot saturated", v, 255);
        track(v); check("R6 cleared after snapshot", v, 0);
        alt_mode = 0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule